// File: doc/BRIEF.md
# Management Status Stream Serializer

This block turns a repeated frame into a management serial bus that a network controller can capture. The frame arrives one bit per clock, where each clock is one network bit time. A level marks the frame and a one-cycle marker flags the last bit of the start-of-frame delimiter. On the bus side the block drives a carrier-sense level, a clock-enable strobe that stands in for the gated receive clock, and an NRZ data bit that is valid whenever the strobe is high.

Once the frame ends, the block appends a 56-bit status field, supplied at the inputs, seven bytes sent first byte first and least significant bit first. If the frame data stopped off a byte boundary, zero bits come first so that the status starts on one. A compress request can cut the data field short after a programmed number of bytes past the delimiter. While clocking is stalled this way, carrier stays up until the frame ends. A filter drops frames that carry no delimiter. A threshold on idle bit times keeps frames that follow the previous one too closely from being clocked out.

Top module: `mgmt_stat_ser`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with the frame input idle, `bus_crs`, `bus_clk_en` and `bus_dat` are all 0.
- R2: With `cfg_sfd_only`=0 a frame is forwarded from its first bit. Every frame bit appears once on `bus_dat` with one `bus_clk_en` strobe, in arrival order.
- R3: With `cfg_sfd_only`=1 forwarding starts with the delimiter byte: the 7 bits before the bit flagged by `frm_sfd`, then that bit. A frame with no `frm_sfd` pulse raises neither carrier nor strobe.
- R4: Let N be `cfg_comp_bytes`. If `comp_req` is high at any point of the frame up to the bit time of the first bit after N data bytes past the delimiter, then that bit and all later data bits get no strobe.
- R5: If `comp_req` first rises after that bit time, the whole frame is forwarded.
- R6: If the frame ends before N data bytes and one further bit have been received, the whole frame is forwarded, and compress has no effect.
- R7: After a truncation, carrier stays asserted with no strobes until the frame ends. The status field then follows with no pad bits.
- R8: If the count of forwarded bits after the delimiter bit is not a multiple of 8, zero-valued strobed bits are inserted until it is. The count runs from the frame's first bit when there is no delimiter.
- R9: The status field is 56 strobed bits, `stat_in[0]` first through `stat_in[55]`. Bit 1 is sent as `stat_in[1]` ORed with a flag that is 1 only when truncation took place in this frame.
- R10: A frame is clocked out only if more than `cfg_gap_thr` bus bit times with carrier low come before its carrier rises. Otherwise carrier is held for the frame's length plus one bit time, with no strobes and no status.
- R11: Between the last frame bit time and the first pad or status bit there is exactly one bit time with carrier high and no strobe. `bus_clk_en` is never high while `bus_crs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_act | input | 1 | High for every bit time of the repeated frame |
| frm_bit | input | 1 | Frame data bit |
| frm_sfd | input | 1 | Pulses on the last bit of the start-of-frame delimiter |
| comp_req | input | 1 | Compress request |
| cfg_sfd_only | input | 1 | 1: forward only frames that carry a delimiter |
| cfg_comp_bytes | input | DEC_W | Data bytes kept after the delimiter when compressing |
| cfg_gap_thr | input | THR_W | Minimum idle gap minus one, in bit times |
| stat_in | input | 8*STAT_BYTES | Status field, byte 0 in bits 7:0 |
| bus_crs | output | 1 | Carrier sense |
| bus_clk_en | output | 1 | Gated clock strobe, one per transferred bit |
| bus_dat | output | 1 | NRZ data, valid with the strobe |

## Verification
The assertions check on every cycle that no strobe occurs without carrier, that a compress stall and a gap-suppressed frame keep carrier up with the strobe silent, and that each status-tail cycle yields a strobe. Which bits appear and in what order cannot be seen from one cycle. That covers the boundary at which truncation bites and the missed-deadline case, the delimiter alignment, the pad length, the flag folded into the status, and the exact idle count that separates a clocked frame from a muted one. The bench shows these by sweeping byte counts, request timings and frame lengths, and by setting the idle gap either side of the threshold.

// File: rtl/mgmt_stat_ser.sv
module mgmt_stat_ser #(
  parameter int DEC_W      = 16,
  parameter int THR_W      = 8,
  parameter int STAT_BYTES = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_act,
  input  logic                    frm_bit,
  input  logic                    frm_sfd,
  input  logic                    comp_req,
  input  logic                    cfg_sfd_only,
  input  logic [DEC_W-1:0]        cfg_comp_bytes,
  input  logic [THR_W-1:0]        cfg_gap_thr,
  input  logic [8*STAT_BYTES-1:0] stat_in,
  output logic                    bus_crs,
  output logic                    bus_clk_en,
  output logic                    bus_dat
);

  localparam int STAT_W = 8 * STAT_BYTES;
  localparam int DLY    = 7;
  localparam int GAP_W  = THR_W + 1;
  localparam int TCNT_W = $clog2(STAT_W);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_PASS  = 3'd1;
  localparam logic [2:0] S_STALL = 3'd2;
  localparam logic [2:0] S_TAIL  = 3'd3;
  localparam logic [2:0] S_MUTE  = 3'd4;

  logic [DLY:0]        act_dl;
  logic [DLY-1:0]      bit_dl, sfd_dl;
  logic [2:0]          st;
  logic                sfd_seen, arm, done;
  logic [2:0]          bitcnt;
  logic [DEC_W-1:0]    bytecnt;
  logic [GAP_W-1:0]    gap;
  logic [TCNT_W-1:0]   tcnt;
  logic [STAT_W-1:0]   stat_sh;

  wire d_act   = act_dl[DLY-1];
  wire d_act_q = act_dl[DLY];
  wire d_bit   = bit_dl[DLY-1];
  wire d_sfd   = sfd_dl[DLY-1];

  wire in_idle   = (st == S_IDLE);
  wire in_tail   = (st == S_TAIL);
  wire start     = in_idle & d_act & (cfg_sfd_only ? frm_sfd : ~d_act_q);
  wire gap_ok    = gap > {1'b0, cfg_gap_thr};
  wire go_pass   = start & gap_ok;
  wire go_mute   = start & ~gap_ok;
  wire pass_cyc  = d_act & ((st == S_PASS) | go_pass);
  wire trunc_now = pass_cyc & sfd_seen & (arm | comp_req) &
                   (bitcnt == 3'd0) & (bytecnt == cfg_comp_bytes);
  wire emit_data = pass_cyc & ~trunc_now;
  wire pad_now   = in_tail & (bitcnt != 3'd0);
  wire [STAT_W-1:0] stat_ld = stat_in | {{(STAT_W-2){1'b0}}, done, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_dl <= '0;
      bit_dl <= '0;
      sfd_dl <= '0;
    end else begin
      act_dl <= {act_dl[DLY-1:0], frm_act};
      bit_dl <= {bit_dl[DLY-2:0], frm_bit};
      sfd_dl <= {sfd_dl[DLY-2:0], frm_sfd};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sfd_seen   <= 1'b0;
      arm        <= 1'b0;
      done       <= 1'b0;
      bitcnt     <= '0;
      bytecnt    <= '0;
      gap        <= '1;
      tcnt       <= '0;
      stat_sh    <= '0;
      bus_crs    <= 1'b0;
      bus_clk_en <= 1'b0;
      bus_dat    <= 1'b0;
    end else begin
      bus_crs    <= ~in_idle | start;
      bus_clk_en <= emit_data | in_tail;
      bus_dat    <= emit_data ? d_bit : (in_tail & ~pad_now & stat_sh[0]);

      case (st)
        S_IDLE: begin
          sfd_seen <= 1'b0;
          arm      <= 1'b0;
          done     <= 1'b0;
          bitcnt   <= '0;
          bytecnt  <= '0;
          tcnt     <= '0;
          if (go_pass)      st <= S_PASS;
          else if (go_mute) st <= S_MUTE;
          else if (!(&gap)) gap <= gap + GAP_W'(1);
        end
        S_PASS: begin
          if (trunc_now) begin
            st   <= S_STALL;
            done <= 1'b1;
          end else if (!d_act) begin
            st      <= S_TAIL;
            stat_sh <= stat_ld;
          end
        end
        S_STALL: begin
          if (!d_act) begin
            st      <= S_TAIL;
            stat_sh <= stat_ld;
          end
        end
        S_TAIL: begin
          if (pad_now) begin
            bitcnt <= bitcnt + 3'd1;
          end else begin
            stat_sh <= stat_sh >> 1;
            tcnt    <= tcnt + TCNT_W'(1);
            if (tcnt == TCNT_W'(STAT_W - 1)) begin
              st  <= S_IDLE;
              gap <= '0;
            end
          end
        end
        S_MUTE: begin
          if (!d_act) begin
            st  <= S_IDLE;
            gap <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (pass_cyc && comp_req) arm <= 1'b1;

      if (emit_data) begin
        if (d_sfd) begin
          sfd_seen <= 1'b1;
          bitcnt   <= '0;
          bytecnt  <= '0;
        end else begin
          bitcnt <= bitcnt + 3'd1;
          if (sfd_seen && bitcnt == 3'd7 && !(&bytecnt))
            bytecnt <= bytecnt + DEC_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/mgmt_stat_ser_chk.sv
module mgmt_stat_ser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_crs,
  input logic       bus_clk_en,
  input logic [2:0] st
);

  localparam logic [2:0] C_STALL = 3'd2;
  localparam logic [2:0] C_TAIL  = 3'd3;
  localparam logic [2:0] C_MUTE  = 3'd4;

  assert_strobe_under_carrier_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_en |-> bus_crs);

  assert_stall_holds_carrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_STALL) |=> (bus_crs && !bus_clk_en));

  assert_short_gap_muted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_MUTE) |=> (bus_crs && !bus_clk_en));

  assert_tail_strobed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_TAIL) |=> (bus_crs && bus_clk_en));

endmodule

bind mgmt_stat_ser mgmt_stat_ser_chk u_chk (.*);

// File: tb/sim_mgmt_stat_ser.sv
module sim_mgmt_stat_ser;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, frm_act, frm_bit, frm_sfd, comp_req, cfg_sfd_only;
  logic [15:0] cfg_comp_bytes;
  logic [7:0]  cfg_gap_thr;
  logic [55:0] stat_in;
  logic        bus_crs, bus_clk_en, bus_dat;

  mgmt_stat_ser u0 (
    .clk(clk), .rst_n(rst_n), .frm_act(frm_act), .frm_bit(frm_bit), .frm_sfd(frm_sfd),
    .comp_req(comp_req), .cfg_sfd_only(cfg_sfd_only), .cfg_comp_bytes(cfg_comp_bytes),
    .cfg_gap_thr(cfg_gap_thr), .stat_in(stat_in),
    .bus_crs(bus_crs), .bus_clk_en(bus_clk_en), .bus_dat(bus_dat)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cap [0:2047];
  bit ex  [0:2047];
  int cap_n = 0;
  int crs_n = 0;
  bit mon_en = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (bus_crs) crs_n++;
      if (bus_clk_en) begin
        if (cap_n < 2048) cap[cap_n] = bus_dat;
        cap_n++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit fb(input int j, input int seed);
    return bit'(((j * 7 + seed + (j >> 2)) % 3) == 1);
  endfunction

  task automatic drive_frame(input int len, input int p, input bit has_sfd,
                             input bit pc_on, input int cp, input int seed, input int tail);
    for (int c = 0; c < len + tail; c++) begin
      frm_act  = (c < len);
      frm_bit  = (c < len) ? fb(c, seed) : 1'b0;
      frm_sfd  = has_sfd && (c == p);
      comp_req = pc_on && (c >= cp);
      @(negedge clk);
    end
    frm_act = 0; frm_bit = 0; frm_sfd = 0; comp_req = 0;
  endtask

  task automatic scenario(input bit filt, input int len, input int p, input bit has_sfd,
                          input bit pc_on, input int cp, input int n, input int seed);
    bit started, trunc;
    int s0, tb, last, pad, ex_n, crs_exp, bad_d, bad_s;
    string tag;
    cfg_sfd_only   = filt;
    cfg_comp_bytes = 16'(n);
    stat_in        = (56'h0123456789ABCD ^ (56'(seed) * 56'h1111)) & ~56'h2;
    @(posedge clk);
    cap_n = 0; crs_n = 0; mon_en = 1;
    @(negedge clk);
    drive_frame(len, p, has_sfd, pc_on, cp, seed, 110);
    mon_en = 0;

    started = !filt || has_sfd;
    if (!started) begin
      check(crs_n == 0, "R3 carrier on frame without delimiter", crs_n, 0);
      check(cap_n == 0, "R3 strobes on frame without delimiter", cap_n, 0);
      return;
    end
    s0    = filt ? p - 7 : 0;
    tb    = p + 1 + 8 * n;
    trunc = has_sfd && pc_on && (tb < len) && (cp <= p + 8 + 8 * n);
    last  = trunc ? tb - 1 : len - 1;
    pad   = trunc ? 0 : (has_sfd ? (8 - ((len - 1 - p) % 8)) % 8 : (8 - (len % 8)) % 8);
    ex_n  = 0;
    for (int j = s0; j <= last; j++) begin ex[ex_n] = fb(j, seed); ex_n++; end
    for (int j = 0; j < pad; j++) begin ex[ex_n] = 1'b0; ex_n++; end
    for (int k = 0; k < 56; k++) begin
      ex[ex_n] = (k == 1) ? trunc : stat_in[k];
      ex_n++;
    end
    crs_exp = len - s0 + 1 + pad + 56;

    if (trunc)                         tag = "R4";
    else if (pc_on && has_sfd && tb >= len) tag = "R6";
    else if (pc_on && has_sfd)         tag = "R5";
    else if (pad != 0)                 tag = "R8";
    else if (filt)                     tag = "R3";
    else                               tag = "R2";

    check(cap_n == ex_n, {tag, " strobe count"}, cap_n, ex_n);
    bad_d = 0; bad_s = 0;
    if (cap_n == ex_n) begin
      for (int j = 0; j < ex_n - 56; j++) if (cap[j] != ex[j]) bad_d++;
      for (int j = ex_n - 56; j < ex_n; j++) if (cap[j] != ex[j]) bad_s++;
    end
    check(bad_d == 0, {tag, " data/pad bit mismatches"}, bad_d, 0);
    check(bad_s == 0, "R9 status bit mismatches", bad_s, 0);
    if (trunc) check(crs_n == crs_exp, "R7 carrier length with stall", crs_n, crs_exp);
    else       check(crs_n == crs_exp, "R11 carrier length", crs_n, crs_exp);
  endtask

  task automatic gap_test(input int thr, input bit wide);
    int w, cnt, exp_clk, exp_crs;
    cfg_sfd_only = 0;
    cfg_gap_thr  = 8'(thr);
    stat_in      = 56'h00FEDCBA987654;
    mon_en = 1;
    drive_frame(20, 0, 1'b0, 1'b0, 0, thr, 0);
    cnt = 0;
    while (!bus_crs && cnt < 200) begin @(negedge clk); cnt++; end
    while (bus_crs && cnt < 400) begin @(negedge clk); cnt++; end
    w = thr - 8 + (wide ? 1 : 0);
    for (int i = 0; i < w; i++) @(negedge clk);
    cap_n = 0; crs_n = 0;
    drive_frame(20, 0, 1'b0, 1'b0, 0, thr + 3, 110);
    mon_en = 0;
    exp_clk = wide ? 20 + 4 + 56 : 0;
    exp_crs = wide ? 20 + 1 + 4 + 56 : 21;
    check(cap_n == exp_clk, "R10 strobes after gap", cap_n, exp_clk);
    check(crs_n == exp_crs, "R10 carrier after gap", crs_n, exp_crs);
    cfg_gap_thr = 0;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; frm_act = 0; frm_bit = 0; frm_sfd = 0; comp_req = 0;
    cfg_sfd_only = 0; cfg_comp_bytes = 0; cfg_gap_thr = 0; stat_in = '0;
    repeat (4) @(negedge clk);
    check({bus_crs, bus_clk_en, bus_dat} == 3'b000, "R1 outputs in reset",
          int'({bus_crs, bus_clk_en, bus_dat}), 0);
    rst_n = 1;
    @(negedge clk);
    check({bus_crs, bus_clk_en, bus_dat} == 3'b000, "R1 outputs after reset",
          int'({bus_crs, bus_clk_en, bus_dat}), 0);

    for (int filt = 0; filt < 2; filt++)
      for (int n = 0; n < 4; n++)
        for (int mode = 0; mode < 4; mode++)
          for (int lv = 0; lv < 3; lv++) begin
            int p, len, cp;
            p   = 12;
            len = (lv == 0) ? p + 1 + 8 * n : (lv == 1) ? p + 6 + 8 * n : p + 21 + 8 * n;
            cp  = (mode == 1) ? 0 : (mode == 2) ? p + 8 + 8 * n : p + 9 + 8 * n;
            scenario(bit'(filt), len, p, 1'b1, mode != 0, cp, n, filt * 50 + n * 12 + mode * 3 + lv);
          end

    scenario(1'b1, 30, 12, 1'b0, 1'b0, 0, 0, 7);
    scenario(1'b0, 27, 12, 1'b0, 1'b1, 0, 0, 9);
    scenario(1'b0, 32, 12, 1'b0, 1'b0, 0, 0, 4);

    for (int thr = 8; thr < 14; thr++) begin
      gap_test(thr, 1'b0);
      gap_test(thr, 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule